// File: doc/BRIEF.md
# NOR Flash Toggle-Bit Completion Poller

This block decides when an embedded program or erase job inside a NOR flash has ended, and how it ended. After the command sequence has been written by other logic, a single `start` pulse hands the poller the status address and a cycle budget. The poller then reads that address over a simple request/acknowledge read port and watches two status bits. The first is a toggle bit that flips on every read while the device is working. The second is a fault bit that the device raises when its internal time limit has been exceeded.

Reads are taken in pairs. When the toggle bit agrees across a pair, the job is finished. When it disagrees and the fault bit of the first read is set, a second pair is read to tell a late finish from a real failure. A free-running elapsed counter, started by `start`, limits the whole search. The outcome is held on `result` and announced with a one-cycle `done` pulse.

Top module: `nor_toggle_poller`

## Requirements
- R1: After reset `busy`, `done` and `rd_req` are low and `result` is 2'b00 (ongoing).
- R2: Every read uses the address captured at `start`. `rd_req` and `rd_addr` stay steady until the cycle in which `rd_ack` is high, and `rd_data` is taken in that cycle.
- R3: If bit 6 is equal in both reads of a pair, polling ends with `result` 2'b01 (success).
- R4: If bit 6 differs across the pair and bit 5 of the first read is clear, a new pair is read after the time check.
- R5: If bit 6 differs and bit 5 of the first read is set, a re-check pair is read at once. If its bit 6 values agree, the result is success.
- R6: If the re-check pair still toggles, the result is 2'b10 (error) when bit 5 of its first read is set. If that bit is clear, polling continues with a new pair.
- R7: A timeout limit of zero ends polling with 2'b11 (timeout) and issues no read.
- R8: Before each pair, polling ends with timeout if the elapsed cycle count exceeds the limit. The count starts at `start` and is never cleared between pairs.
- R9: `done` is a one-cycle pulse in the cycle `busy` falls. `result` reads ongoing while busy and keeps the final code until the next accepted `start`.
- R10: A `start` pulse while busy is ignored: address, limit and the sequence of reads are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin polling (accepted only when idle) |
| poll_addr | input | AW | Status address to read |
| tmo_limit | input | TW | Elapsed-cycle budget; zero means immediate timeout |
| rd_req | output | 1 | Read request to the flash bus |
| rd_addr | output | AW | Read address |
| rd_ack | input | 1 | Read completed, `rd_data` valid |
| rd_data | input | DW | Data returned by the read |
| busy | output | 1 | Polling in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 00 ongoing, 01 success, 10 error, 11 timeout |

## Verification
The bound checker checks the handshake and result rules on every cycle. It covers the held request and address while a read is pending, and requests only while busy. It also covers the single-cycle `done` that coincides with the fall of `busy`, the ongoing code while busy, and the final code staying put while idle. The decision logic can only be shown by the bench's scenarios. These are immediate finish, long toggling, a late finish after the fault bit, a hard error, a fault bit that clears on re-check, the zero and cumulative timeouts, and a start that arrives while busy. A scripted flash model and a reference walk of the algorithm predict both the code and the exact number of reads for each scenario.

// File: rtl/nor_toggle_poller.sv
module nor_toggle_poller #(
  parameter int AW      = 24,
  parameter int DW      = 16,
  parameter int TW      = 16,
  parameter int TOG_BIT = 6,
  parameter int ERR_BIT = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] poll_addr,
  input  logic [TW-1:0] tmo_limit,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ack,
  input  logic [DW-1:0] rd_data,
  output logic          busy,
  output logic          done,
  output logic [1:0]    result
);
  localparam logic [1:0] RES_RUN = 2'b00;
  localparam logic [1:0] RES_OK  = 2'b01;
  localparam logic [1:0] RES_ERR = 2'b10;
  localparam logic [1:0] RES_TMO = 2'b11;
  localparam int CW = TW + 1;

  typedef enum logic [2:0] {S_IDLE, S_CHK, S_RA, S_RB, S_RC, S_RD} st_t;

  st_t           st;
  logic [AW-1:0] addr_q;
  logic [TW-1:0] lim_q;
  logic [CW-1:0] elapsed;
  logic [DW-1:0] first_q;
  logic          same_tog;
  logic          expired;

  assign same_tog = first_q[TOG_BIT] == rd_data[TOG_BIT];
  assign expired  = (lim_q == '0) || (elapsed > {1'b0, lim_q});
  assign busy     = st != S_IDLE;
  assign rd_req   = (st == S_RA) || (st == S_RB) || (st == S_RC) || (st == S_RD);
  assign rd_addr  = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      addr_q  <= '0;
      lim_q   <= '0;
      elapsed <= '0;
      first_q <= '0;
      done    <= 1'b0;
      result  <= RES_RUN;
    end else begin
      done <= 1'b0;
      if (st != S_IDLE && elapsed != '1) elapsed <= elapsed + 1'b1;
      case (st)
        S_IDLE: if (start) begin
          addr_q  <= poll_addr;
          lim_q   <= tmo_limit;
          elapsed <= '0;
          result  <= RES_RUN;
          st      <= S_CHK;
        end
        S_CHK: begin
          if (expired) begin
            result <= RES_TMO;
            done   <= 1'b1;
            st     <= S_IDLE;
          end else begin
            st <= S_RA;
          end
        end
        S_RA: if (rd_ack) begin
          first_q <= rd_data;
          st      <= S_RB;
        end
        S_RB: if (rd_ack) begin
          if (same_tog) begin
            result <= RES_OK;
            done   <= 1'b1;
            st     <= S_IDLE;
          end else if (first_q[ERR_BIT]) begin
            st <= S_RC;
          end else begin
            st <= S_CHK;
          end
        end
        S_RC: if (rd_ack) begin
          first_q <= rd_data;
          st      <= S_RD;
        end
        S_RD: if (rd_ack) begin
          if (same_tog) begin
            result <= RES_OK;
            done   <= 1'b1;
            st     <= S_IDLE;
          end else if (first_q[ERR_BIT]) begin
            result <= RES_ERR;
            done   <= 1'b1;
            st     <= S_IDLE;
          end else begin
            st <= S_CHK;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nor_toggle_poller_chk.sv
module nor_toggle_poller_chk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          rd_req,
  input logic [AW-1:0] rd_addr,
  input logic          rd_ack,
  input logic          busy,
  input logic          done,
  input logic [1:0]    result
);
  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));
  // R2
  req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> busy);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  done_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R9
  done_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result != 2'b00 && !busy));
  // R9
  run_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> result == 2'b00);
  // R9
  hold_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(result));
endmodule

bind nor_toggle_poller nor_toggle_poller_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .rd_req(rd_req), .rd_addr(rd_addr),
  .rd_ack(rd_ack), .busy(busy), .done(done), .result(result)
);

// File: tb/sim_nor_toggle_poller.sv
module sim_nor_toggle_poller;
  localparam int CLK_NS = 10;
  localparam int AW = 24, DW = 16, TW = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] poll_addr = '0;
  logic [TW-1:0] tmo_limit = '0;
  logic rd_req, rd_ack = 1'b0, busy, done;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data = '0;
  logic [1:0] result;

  always #(CLK_NS/2) clk = ~clk;

  nor_toggle_poller #(.AW(AW), .DW(DW), .TW(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .poll_addr(poll_addr),
    .tmo_limit(tmo_limit), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
    .rd_data(rd_data), .busy(busy), .done(done), .result(result));

  int tests = 0, fails = 0;

  // flash model script
  int m_tog = 0, m_ffrom = 1000, m_fto = 1000, m_lat = 0, m_k = 0, m_wait = 0;
  logic [AW-1:0] m_addr = '0;
  int addr_bad = 0;

  function automatic logic b6(int k, int tog);
    return ((k < tog) ? k : tog) % 2 == 1;
  endfunction
  function automatic logic b5(int k, int ff, int ft);
    return (k >= ff) && (k < ft);
  endfunction

  always @(posedge clk) begin
    if (rd_ack) rd_ack <= 1'b0;
    else if (rd_req) begin
      if (m_wait >= m_lat) begin
        logic [DW-1:0] d;
        d = 16'h1A9F & ~16'h0060;
        d[6] = b6(m_k, m_tog);
        d[5] = b5(m_k, m_ffrom, m_fto);
        rd_data <= d;
        rd_ack <= 1'b1;
        if (rd_addr != m_addr) addr_bad = addr_bad + 1;
        m_k = m_k + 1;
        m_wait = 0;
      end else m_wait = m_wait + 1;
    end
  end

  // reference walk of the algorithm: returns code, sets read count
  function automatic logic [1:0] ref_poll(int tog, int ff, int ft, output int nreads);
    int k = 0;
    for (int it = 0; it < 500; it++) begin
      if (b6(k, tog) == b6(k+1, tog)) begin nreads = k + 2; return 2'b01; end
      if (!b5(k, ff, ft)) begin k += 2; continue; end
      if (b6(k+2, tog) == b6(k+3, tog)) begin nreads = k + 4; return 2'b01; end
      if (b5(k+2, ff, ft)) begin nreads = k + 4; return 2'b10; end
      k += 4;
    end
    nreads = -1;
    return 2'b11;
  endfunction

  typedef struct { logic [1:0] res; int reads; string tag; } exp_t;
  exp_t sb[$];

  task automatic check(bit ok, string tag, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) check(0, "R9", "unexpected done", 1, 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        check(result == e.res, e.tag, "result", int'(result), int'(e.res));
        if (e.reads >= 0) check(m_k == e.reads, e.tag, "read count", m_k, e.reads);
        check(addr_bad == 0, "R2", "address mismatches", addr_bad, 0);
      end
    end
  end

  task automatic run(int tog, int ff, int ft, int lim, int lat, logic [AW-1:0] a,
                     logic [1:0] xres, int xreads, string tag, bit poke = 0);
    exp_t e;
    @(negedge clk);
    m_tog = tog; m_ffrom = ff; m_fto = ft; m_lat = lat; m_k = 0; m_wait = 0;
    m_addr = a; addr_bad = 0;
    e.res = xres; e.reads = xreads; e.tag = tag;
    sb.push_back(e);
    poll_addr = a; tmo_limit = lim[TW-1:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy && result == 2'b00, "R9", "busy with ongoing code", int'(result), 0);
    if (poke) begin
      repeat (3) @(negedge clk);
      poll_addr = a ^ 24'h00FFFF; tmo_limit = '0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    check(result == xres, "R9", "held code", int'(result), int'(xres));
    check(sb.size() == 0, tag, "pending items", sb.size(), 0);
  endtask

  initial begin
    int n;
    logic [1:0] r;
    repeat (3) @(negedge clk);
    check(!busy && !done && !rd_req && result == 2'b00, "R1", "reset state",
          int'({busy, done, rd_req}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && result == 2'b00, "R1", "idle after reset", int'(result), 0);

    r = ref_poll(0, 1000, 1000, n);       run(0, 1000, 1000, 500, 0, 24'h000AA0, r, n, "R3");
    r = ref_poll(5, 1000, 1000, n);       run(5, 1000, 1000, 500, 2, 24'h012340, r, n, "R4");
    r = ref_poll(1, 0, 1000, n);          run(1, 0, 1000, 500, 1, 24'h003000, r, n, "R5");
    r = ref_poll(1000, 0, 1000, n);       run(1000, 0, 1000, 500, 0, 24'h7FFFFE, r, n, "R6");
    r = ref_poll(1000, 3, 1000, n);       run(1000, 3, 1000, 500, 1, 24'h100000, r, n, "R6");
    r = ref_poll(6, 0, 1, n);             run(6, 0, 1, 500, 0, 24'h000555, r, n, "R6");
    run(1000, 1000, 1000, 0, 0, 24'h0002AA, 2'b11, 0, "R7");
    run(100000, 1000, 1000, 40, 1, 24'h0ABCDE, 2'b11, -1, "R8");
    r = ref_poll(1000, 3, 1000, n);       run(1000, 3, 1000, 500, 2, 24'h055550, r, n, "R10", 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule